// File: doc/BRIEF.md
# Prescaled PWM Timer

This block produces a single pulse-width-modulated output from a down-counting timer. The main count is extended at its top by a small prescale field. Together they form one wide count that sets the period, and a second wide value of the same shape sets the duty point. While enabled, the timer runs without stopping. Each time the count passes zero it reloads from the period value. The output is active while the count is above the duty value, and an invert control can flip the pin.

Transitions of the output are detected as events. Software picks which of them count: rising, falling or both. Events are judged on the uninverted waveform, so turning on the invert control reverses the pin edge that each selection responds to. A sticky status bit records selected events and is cleared by a write-one pulse. The interrupt line is that status gated by an enable. All settings other than the period are meant to be written while the timer is disabled. The period may be changed while the timer runs, and the new value is used from the next reload.

Top module: `pwm_timer`

## Requirements
- R1: While reset is asserted and on the first cycle after it, the counter is zero, the uninverted waveform is low (so the pin equals the invert control), and the interrupt is low.
- R2: The reload value is {load_ext_i, load_i}, with the extension as the upper bits. On the first enabled clock edge the count becomes the reload value L. It then drops by one per cycle to zero and reloads, giving a period of L+1 cycles.
- R3: The uninverted waveform is high exactly while the count is greater than {match_ext_i, match_i}. A duty value of L or more gives a waveform that is always low. A duty value of 0 gives L high cycles out of every L+1.
- R4: pwm_o equals the uninverted waveform when inv_i is 0, and its complement when inv_i is 1.
- R5: When en_i is low, the counter clears and the waveform drops low at the next edge. Dropping enable raises no event.
- R6: Events follow evt_sel_i: 2'b00 selects a rise of the uninverted waveform, 2'b01 selects a fall, and 2'b10 or 2'b11 select both. When inv_i is 1, the matching pin edges are therefore the reverse.
- R7: The status bit is set by a selected event and held until a clock edge with clr_i high. If an event and clr_i occur on the same edge, the set takes priority.
- R8: irq_o is high exactly when the status bit is set and irq_en_i is 1. Changing irq_en_i leaves the status unchanged.
- R9: A reload value written while the timer runs does not shorten the period in progress. The count first reaches zero, then reloads with the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Run enable |
| inv_i | input | 1 | Output invert |
| evt_sel_i | input | 2 | Event select (00 rise, 01 fall, 1x both) |
| irq_en_i | input | 1 | Interrupt enable |
| load_i | input | CNT_W | Period value, lower part |
| load_ext_i | input | PRE_W | Period value, prescale upper part |
| match_i | input | CNT_W | Duty value, lower part |
| match_ext_i | input | PRE_W | Duty value, prescale upper part |
| clr_i | input | 1 | Write-one-to-clear pulse for the status |
| pwm_o | output | 1 | PWM pin |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the timer with CNT_W=3 and PRE_W=1. This gives a 4-bit combined count, so all 256 pairs of period and duty value can be run, each with both invert settings and all four event selections. Every cycle of two full periods is compared with a count position and waveform level worked out in closed form. Under this configuration the extension bit carries into both the reload and the compare. The zero-period and zero-duty corners also fall inside the sweep. Separate sequences cover a period change in mid-run, a clear that coincides with an event, interrupt masking, and disabling while the output is high.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;

    typedef enum logic [1:0] {
        EVT_RISE  = 2'b00,
        EVT_FALL  = 2'b01,
        EVT_BOTH  = 2'b10,
        EVT_BOTH2 = 2'b11
    } evt_sel_e;

    typedef struct packed {
        logic rise;
        logic fall;
    } edge_t;

    function automatic logic evt_selected(input evt_sel_e sel, input edge_t e);
        case (sel)
            EVT_RISE: return e.rise;
            EVT_FALL: return e.fall;
            default:  return e.rise | e.fall;
        endcase
    endfunction

endpackage

// File: rtl/pwm_tmr_count.sv
module pwm_tmr_count #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic [W-1:0] reload_val,
    output logic [W-1:0] cnt_q,
    output logic [W-1:0] cnt_nxt
);

    always_comb begin
        if (!en)
            cnt_nxt = '0;
        else if (cnt_q == '0)
            cnt_nxt = reload_val;
        else
            cnt_nxt = cnt_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else
            cnt_q <= cnt_nxt;
    end

endmodule

// File: rtl/pwm_tmr_cmp.sv
module pwm_tmr_cmp
    import pwm_timer_pkg::*;
#(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic [W-1:0] cnt_nxt,
    input  logic [W-1:0] match_val,
    output logic         raw_q,
    output edge_t        edges
);

    logic raw_nxt;

    always_comb begin
        raw_nxt    = en && (cnt_nxt > match_val);
        edges.rise = en && raw_nxt && !raw_q;
        edges.fall = en && !raw_nxt && raw_q;
    end

    always_ff @(posedge clk) begin
        if (rst)
            raw_q <= 1'b0;
        else
            raw_q <= raw_nxt;
    end

endmodule

// File: rtl/pwm_tmr_status.sv
module pwm_tmr_status
    import pwm_timer_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  evt_sel_e sel,
    input  edge_t    edges,
    input  logic     clr,
    input  logic     irq_en,
    output logic     stat_q,
    output logic     hit,
    output logic     irq
);

    always_comb begin
        hit = evt_selected(sel, edges);
        irq = stat_q & irq_en;
    end

    always_ff @(posedge clk) begin
        if (rst)
            stat_q <= 1'b0;
        else if (hit)
            stat_q <= 1'b1;
        else if (clr)
            stat_q <= 1'b0;
    end

endmodule

// File: rtl/pwm_timer.sv
module pwm_timer
    import pwm_timer_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int PRE_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en_i,
    input  logic             inv_i,
    input  logic [1:0]       evt_sel_i,
    input  logic             irq_en_i,
    input  logic [CNT_W-1:0] load_i,
    input  logic [PRE_W-1:0] load_ext_i,
    input  logic [CNT_W-1:0] match_i,
    input  logic [PRE_W-1:0] match_ext_i,
    input  logic             clr_i,
    output logic             pwm_o,
    output logic             irq_o
);

    localparam int FULL_W = CNT_W + PRE_W;

    logic [FULL_W-1:0] reload_full;
    logic [FULL_W-1:0] match_full;
    logic [FULL_W-1:0] cnt_q;
    logic [FULL_W-1:0] cnt_nxt;
    logic              raw_q;
    edge_t             edges;
    logic              stat_q;
    logic              evt_hit;
    evt_sel_e          sel;

    assign reload_full = {load_ext_i, load_i};
    assign match_full  = {match_ext_i, match_i};
    assign sel         = evt_sel_e'(evt_sel_i);

    pwm_tmr_count #(.W(FULL_W)) u_count (
        .clk        (clk),
        .rst        (rst),
        .en         (en_i),
        .reload_val (reload_full),
        .cnt_q      (cnt_q),
        .cnt_nxt    (cnt_nxt)
    );

    pwm_tmr_cmp #(.W(FULL_W)) u_cmp (
        .clk       (clk),
        .rst       (rst),
        .en        (en_i),
        .cnt_nxt   (cnt_nxt),
        .match_val (match_full),
        .raw_q     (raw_q),
        .edges     (edges)
    );

    pwm_tmr_status u_status (
        .clk    (clk),
        .rst    (rst),
        .sel    (sel),
        .edges  (edges),
        .clr    (clr_i),
        .irq_en (irq_en_i),
        .stat_q (stat_q),
        .hit    (evt_hit),
        .irq    (irq_o)
    );

    assign pwm_o = raw_q ^ inv_i;

endmodule

// File: rtl/pwm_timer_chk.sv
module pwm_timer_chk #(
    parameter int CNT_W = 16,
    parameter int PRE_W = 8
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   en_i,
    input logic                   inv_i,
    input logic [CNT_W-1:0]       load_i,
    input logic [PRE_W-1:0]       load_ext_i,
    input logic                   clr_i,
    input logic                   pwm_o,
    input logic [CNT_W+PRE_W-1:0] cnt_q,
    input logic                   stat_q,
    input logic                   evt_hit
);

    localparam int FULL_W = CNT_W + PRE_W;

    // R5: one edge after a disabled cycle the pin sits at the inactive level
    a_r5_idle_level: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(!en_i)) |-> (pwm_o == inv_i));

    // R2: a running non-zero count steps down by one
    a_r2_count_down: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(en_i) && $past(cnt_q) != '0)
            |-> (cnt_q == FULL_W'($past(cnt_q) - 1'b1)));

    // R2: a running zero count reloads from the period inputs
    a_r2_reload: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(en_i) && $past(cnt_q) == '0)
            |-> (cnt_q == $past({load_ext_i, load_i})));

    // R7: a clear with no coincident event leaves the status low
    a_r7_clear: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(clr_i) && !$past(evt_hit)) |-> !stat_q);

    // R7: the status stays set until cleared
    a_r7_sticky: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(stat_q) && !$past(clr_i)) |-> stat_q);

endmodule

bind pwm_timer pwm_timer_chk #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_pwm_timer_chk (
    .clk        (clk),
    .rst        (rst),
    .en_i       (en_i),
    .inv_i      (inv_i),
    .load_i     (load_i),
    .load_ext_i (load_ext_i),
    .clr_i      (clr_i),
    .pwm_o      (pwm_o),
    .cnt_q      (cnt_q),
    .stat_q     (stat_q),
    .evt_hit    (evt_hit)
);

// File: tb/test_pwm_timer.sv
`timescale 1ns/1ps
module test_pwm_timer;

    localparam int CNT_W = 3;
    localparam int PRE_W = 1;
    localparam int FULL  = 1 << (CNT_W + PRE_W);

    logic             clk = 1'b0;
    logic             rst;
    logic             en_i;
    logic             inv_i;
    logic [1:0]       evt_sel_i;
    logic             irq_en_i;
    logic [CNT_W-1:0] load_i;
    logic [PRE_W-1:0] load_ext_i;
    logic [CNT_W-1:0] match_i;
    logic [PRE_W-1:0] match_ext_i;
    logic             clr_i;
    logic             pwm_o;
    logic             irq_o;

    int n_checks = 0;
    int n_fails  = 0;
    int cyc      = 0;

    always #2.5 clk = ~clk;

    pwm_timer #(.CNT_W(CNT_W), .PRE_W(PRE_W)) i_pwm_timer (
        .clk         (clk),
        .rst         (rst),
        .en_i        (en_i),
        .inv_i       (inv_i),
        .evt_sel_i   (evt_sel_i),
        .irq_en_i    (irq_en_i),
        .load_i      (load_i),
        .load_ext_i  (load_ext_i),
        .match_i     (match_i),
        .match_ext_i (match_ext_i),
        .clr_i       (clr_i),
        .pwm_o       (pwm_o),
        .irq_o       (irq_o)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: run hung (actual cycles %0d, expected fewer)", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
        end
    endtask

    // Disable, program and clear the status; one idle edge follows.
    task automatic setup(input int L, input int M, input bit inv, input int sel, input bit ien);
        @(negedge clk);
        en_i        = 1'b0;
        inv_i       = inv;
        evt_sel_i   = 2'(sel);
        irq_en_i    = ien;
        {load_ext_i, load_i}   = (CNT_W + PRE_W)'(L);
        {match_ext_i, match_i} = (CNT_W + PRE_W)'(M);
        clr_i       = 1'b1;
        @(negedge clk);
        clr_i = 1'b0;
    endtask

    function automatic bit evt_of(input int sel, input bit prev, input bit cur);
        bit r, f;
        r = cur && !prev;
        f = !cur && prev;
        if (sel == 0) return r;
        if (sel == 1) return f;
        return r | f;
    endfunction

    task automatic run_cfg(input int L, input int M, input bit inv, input int sel);
        bit prev, raw, stat;
        int cnt;
        setup(L, M, inv, sel, 1'b1);
        chk("R5 idle pin level", pwm_o, inv);
        chk("R7 status cleared", irq_o, 0);
        en_i = 1'b1;
        prev = 1'b0;
        stat = 1'b0;
        for (int k = 1; k <= 2 * (L + 1) + 1; k++) begin
            @(negedge clk);
            cnt  = L - ((k - 1) % (L + 1));
            raw  = (cnt > M);
            stat = stat | evt_of(sel, prev, raw);
            prev = raw;
            chk("R2 R3 R4 pin", pwm_o, raw ^ inv);
            chk("R6 R8 irq", irq_o, stat);
        end
    endtask

    initial begin
        rst = 1'b1; en_i = 1'b0; inv_i = 1'b0; evt_sel_i = 2'b00; irq_en_i = 1'b1;
        load_i = '0; load_ext_i = '0; match_i = '0; match_ext_i = '0; clr_i = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 reset pin", pwm_o, 0);
        chk("R1 reset irq", irq_o, 0);
        inv_i = 1'b1;
        #1 chk("R1 reset pin inverted", pwm_o, 1);
        @(negedge clk);
        rst = 1'b0;
        inv_i = 1'b0;
        @(negedge clk);
        chk("R1 after reset irq", irq_o, 0);

        // Sweep of all periods, duty values, invert and event selections
        for (int L = 0; L < FULL; L++)
            for (int M = 0; M < FULL; M++)
                for (int iv = 0; iv < 2; iv++)
                    for (int s = 0; s < 4; s++)
                        run_cfg(L, M, iv[0], s);

        // R9: period change in mid-run
        setup(5, 2, 1'b1, 0, 1'b1);
        en_i = 1'b1;
        for (int k = 1; k <= 3; k++) @(negedge clk);
        {load_ext_i, load_i} = (CNT_W + PRE_W)'(9);
        for (int k = 4; k <= 20; k++) begin
            int cnt;
            @(negedge clk);
            cnt = (k <= 6) ? (6 - k) : (9 - ((k - 7) % 10));
            chk("R9 reload change pin", pwm_o, (cnt > 2) ^ 1);
        end

        // R5: disabling while the waveform is high raises no fall event
        setup(5, 1, 1'b0, 1, 1'b1);
        en_i = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R5 pin high before disable", pwm_o, 1);
        en_i = 1'b0;
        @(negedge clk);
        chk("R5 pin low after disable", pwm_o, 0);
        chk("R5 no event on disable", irq_o, 0);
        @(negedge clk);
        chk("R5 no event later", irq_o, 0);

        // R7 / R8: clear priority and masking
        setup(3, 1, 1'b0, 2, 1'b1);
        en_i = 1'b1;
        @(negedge clk);
        chk("R7 set by rise", irq_o, 1);
        clr_i = 1'b1;
        @(negedge clk);
        chk("R7 cleared without event", irq_o, 0);
        @(negedge clk);
        chk("R7 set wins over clear", irq_o, 1);
        @(negedge clk);
        chk("R7 clear again", irq_o, 0);
        clr_i = 1'b0;
        @(negedge clk);
        chk("R7 set by next rise", irq_o, 1);
        irq_en_i = 1'b0;
        #1 chk("R8 masked", irq_o, 0);
        @(negedge clk);
        irq_en_i = 1'b1;
        #1 chk("R8 status kept under mask", irq_o, 1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule